// File: doc/BRIEF.md
# Quadrature Pulse Counter with Flutter Handling

This block counts switch closures on two clean, already-debounced digital levels, `inA` and `inB`. A 2-bit mode selects one of four behaviours. The block can be off. It can count rising edges of one input, or count rising edges of both inputs on separate counters. It can also decode the pair as a quadrature encoder. In the quadrature case counter 0 moves up or down one step per legal state change. The block tracks the direction of rotation and rejects steps that skip a state.

A 4-bit history of step directions detects flutter, where the shaft rocks back and forth. During flutter the block can freeze both counters. It can instead fall back from quadrature decoding to counting each input's rising edges. Eight sticky event flags, each with an enable, combine into one interrupt line. Software clears a flag by pulsing its bit on `flagClr`.

Top module: `quad_pulse_counter`

## Requirements
- R1: After reset both counters, all flags, `dirCw`, `dirHist`, `flutActive` and `irq` are 0.
- R2: With `mode` = 0 no counter changes and no flag sets, whatever the inputs do.
- R3: With `mode` = 1, `count0` rises by 1 on each rising edge of `inA`. Falling edges and all activity on `inB` leave both counters unchanged.
- R4: With `mode` = 2, `count0` counts rising edges of `inA` and `count1` counts rising edges of `inB`, independently, including when both rise together.
- R5: With `mode` = 3 the state code is {inB,inA}. A move one place forward in the cycle 00,01,11,10 is a clockwise step: `count0` rises by 1 and `dirCw` becomes 1. A move one place back is a counter-clockwise step: `count0` falls by 1 and `dirCw` becomes 0. `count1` holds. `qState` shows the registered code, and `prevA`/`prevB` show the levels held before the last change.
- R6: In `mode` 3 a change of both inputs at once sets flag bit 5 (quadrature error). Outside flutter fallback it leaves `count0` unchanged.
- R7: Each valid quadrature step shifts its direction (1 = clockwise) into `dirHist` bit 0. If the step's direction differs from `dirCw` before the step, flag bit 4 (direction change) sets.
- R8: When a step makes `dirHist` equal 1010 or 0101 and flutter is not active, `flutActive` sets and flag bit 6 sets. When a step during flutter makes `dirHist` equal 0000 or 1111, `flutActive` clears and flag bit 7 sets. Leaving `mode` 3 clears `flutActive` without a flag.
- R9: While `flutActive` and `flutStopEn` are both 1, neither counter changes.
- R10: While `flutActive` and `flutDualEn` are both 1 in `mode` 3, and `flutStopEn` is 0, the counters count rising edges as in `mode` 2 instead of quadrature steps.
- R11: Flag bit 1 (bit 2) sets when `count0` (`count1`) moves to a value equal to `cmpVal0` (`cmpVal1`).
- R12: Flag bit 3 sets when either counter wraps, whether it passes up from all ones to 0 or down from 0 to all ones.
- R13: Flag bit 0 sets on any change of either input level while `mode` is not 0. Flags stay set until `flagClr` pulses that bit with 1. A new event in the same cycle as its clear leaves the flag set.
- R14: `irq` is 1 exactly when some flag bit and the same `flagEn` bit are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inA | input | 1 | Switch input 0 level |
| inB | input | 1 | Switch input 1 level |
| mode | input | 2 | 0 off, 1 single, 2 dual, 3 quadrature |
| flutStopEn | input | 1 | Freeze counters during flutter |
| flutDualEn | input | 1 | Fall back to dual counting during flutter |
| cmpVal0 | input | CNT_W | Compare value for counter 0 |
| cmpVal1 | input | CNT_W | Compare value for counter 1 |
| flagEn | input | 8 | Per-flag interrupt enables |
| flagClr | input | 8 | Write-one-to-clear strobes for flags |
| count0 | output | CNT_W | Counter 0 |
| count1 | output | CNT_W | Counter 1 |
| dirCw | output | 1 | Current direction, 1 clockwise |
| qState | output | 2 | Registered {inB,inA} state code |
| prevA | output | 1 | `inA` level before the last change |
| prevB | output | 1 | `inB` level before the last change |
| dirHist | output | 4 | Last four step directions, bit 0 newest |
| flutActive | output | 1 | Flutter currently detected |
| flags | output | 8 | Sticky event flags |
| irq | output | 1 | Interrupt request |

## Verification
An input change is seen at the first rising clock edge after it. In that same edge the counters, state code, direction, history, flutter status and flags all take their new values. `irq` follows the flag register with no further register. The bench therefore changes inputs, modes and clear strobes on a falling edge and reads every output on the next falling edge, exactly one register stage later. A reference model advanced once per stimulus predicts the values read there. Sweeps cover every from/to pair of input codes in each mode, a full up-wrap of an 8-bit counter, a down-wrap from zero, and flutter entry and exit under both flutter responses.

// File: rtl/qpc_pkg.sv
package qpc_pkg;

  localparam int HIST_W = 4;
  localparam int NFLAG  = 8;

  // flag bit positions (software decodes these)
  localparam int F_TRANS   = 0;
  localparam int F_MATCH0  = 1;
  localparam int F_MATCH1  = 2;
  localparam int F_WRAP    = 3;
  localparam int F_DIRCHG  = 4;
  localparam int F_QERR    = 5;
  localparam int F_FLSTART = 6;
  localparam int F_FLSTOP  = 7;

  typedef enum logic [1:0] {
    MODE_OFF    = 2'd0,
    MODE_SINGLE = 2'd1,
    MODE_DUAL   = 2'd2,
    MODE_QUAD   = 2'd3
  } cntMode_e;

  // strobes from control to datapath, one cycle each
  typedef struct packed {
    logic inc0;
    logic dec0;
    logic inc1;
    logic evTrans;
    logic evDirChg;
    logic evQerr;
    logic evFlStart;
    logic evFlStop;
  } ctrlStrobe_t;

  // position of a Gray state code in the clockwise cycle 00,01,11,10
  function automatic logic [1:0] grayPos(input logic [1:0] code);
    return {code[1], code[1] ^ code[0]};
  endfunction

  // alternating direction pattern ending in the given bit
  function automatic logic [HIST_W-1:0] altPattern(input logic lsb);
    logic [HIST_W-1:0] p;
    for (int i = 0; i < HIST_W; i++) p[i] = lsb ^ logic'(i % 2);
    return p;
  endfunction

endpackage

// File: rtl/qpc_ctrl.sv
module qpc_ctrl
  import qpc_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              inA,
  input  logic              inB,
  input  logic [1:0]        mode,
  input  logic              flutStopEn,
  input  logic              flutDualEn,
  output ctrlStrobe_t       strobe,
  output logic              dirCw,
  output logic [1:0]        qState,
  output logic [1:0]        prevLvl,
  output logic [HIST_W-1:0] dirHist,
  output logic              flutActive
);

  localparam logic [HIST_W-1:0] ALT_LO = altPattern(1'b0);
  localparam logic [HIST_W-1:0] ALT_HI = altPattern(1'b1);
  localparam logic [HIST_W-1:0] UNI_CW = '1;
  localparam logic [HIST_W-1:0] UNI_CC = '0;

  cntMode_e          modeE;
  logic [1:0]        curLvl;
  logic [1:0]        chg;
  logic [1:0]        delta;
  logic              isQuad;
  logic              stepCw;
  logic              stepCcw;
  logic              stepAny;
  logic              badStep;
  logic              rise0;
  logic              rise1;
  logic              flutDual;
  logic              holdCnt;
  logic              edgeCount0;
  logic              edgeCount1;
  logic [HIST_W-1:0] histNext;
  logic              histAlt;
  logic              histUni;

  assign modeE   = cntMode_e'(mode);
  assign curLvl  = {inB, inA};
  assign chg     = curLvl ^ qState;
  assign delta   = grayPos(curLvl) - grayPos(qState);
  assign isQuad  = (modeE == MODE_QUAD);
  assign stepCw  = isQuad && (delta == 2'd1);
  assign stepCcw = isQuad && (delta == 2'd3);
  assign badStep = isQuad && (delta == 2'd2);
  assign stepAny = stepCw || stepCcw;
  assign rise0   = curLvl[0] && !qState[0];
  assign rise1   = curLvl[1] && !qState[1];

  assign flutDual   = flutActive && flutDualEn && isQuad;
  assign holdCnt    = flutActive && flutStopEn;
  assign edgeCount0 = (modeE == MODE_SINGLE) || (modeE == MODE_DUAL) || flutDual;
  assign edgeCount1 = (modeE == MODE_DUAL) || flutDual;

  assign histNext = {dirHist[HIST_W-2:0], stepCw};
  assign histAlt  = (histNext == ALT_LO) || (histNext == ALT_HI);
  assign histUni  = (histNext == UNI_CW) || (histNext == UNI_CC);

  always_comb begin
    strobe           = '0;
    strobe.inc0      = !holdCnt && ((edgeCount0 && rise0) || (isQuad && !flutDual && stepCw));
    strobe.dec0      = !holdCnt && isQuad && !flutDual && stepCcw;
    strobe.inc1      = !holdCnt && edgeCount1 && rise1;
    strobe.evTrans   = (modeE != MODE_OFF) && (chg != 2'b00);
    strobe.evDirChg  = stepAny && (stepCw != dirCw);
    strobe.evQerr    = badStep;
    strobe.evFlStart = stepAny && !flutActive && histAlt;
    strobe.evFlStop  = stepAny && flutActive && histUni;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      qState     <= 2'b00;
      prevLvl    <= 2'b00;
      dirCw      <= 1'b0;
      dirHist    <= '0;
      flutActive <= 1'b0;
    end else begin
      qState <= curLvl;
      if (chg != 2'b00) prevLvl <= qState;
      if (stepAny) begin
        dirCw   <= stepCw;
        dirHist <= histNext;
      end
      if (!isQuad)                 flutActive <= 1'b0;
      else if (strobe.evFlStart)   flutActive <= 1'b1;
      else if (strobe.evFlStop)    flutActive <= 1'b0;
    end
  end

  // R8: flutter status follows its start and stop strobes
  a_r8_start_sets: assert property (@(posedge clk) disable iff (!rstN)
    strobe.evFlStart |=> flutActive);
  a_r8_stop_clears: assert property (@(posedge clk) disable iff (!rstN)
    strobe.evFlStop |=> !flutActive);
  // R5: never both up and down for counter 0
  a_r5_cmd_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.inc0, strobe.dec0}));
  // R7: direction register reflects the latest step
  a_r7_dir_follows: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.inc0 && isQuad && !flutDual) |=> dirCw);

endmodule

// File: rtl/qpc_datapath.sv
module qpc_datapath
  import qpc_pkg::*;
#(
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrobe_t      strobe,
  input  logic [CNT_W-1:0] cmpVal0,
  input  logic [CNT_W-1:0] cmpVal1,
  input  logic [NFLAG-1:0] flagEn,
  input  logic [NFLAG-1:0] flagClr,
  output logic [CNT_W-1:0] count0,
  output logic [CNT_W-1:0] count1,
  output logic [NFLAG-1:0] flags,
  output logic             irq
);

  localparam int NCH = 2;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [NCH-1:0]   upV;
  logic [NCH-1:0]   dnV;
  logic [NCH-1:0]   wrapV;
  logic [NCH-1:0]   matchV;
  logic [CNT_W-1:0] cmpArr [NCH];
  logic [CNT_W-1:0] cntArr [NCH];
  logic [NFLAG-1:0] setV;

  assign upV       = {strobe.inc1, strobe.inc0};
  assign dnV       = {1'b0, strobe.dec0};
  assign cmpArr[0] = cmpVal0;
  assign cmpArr[1] = cmpVal1;

  for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] cntNext;

    always_comb begin
      cntNext = cnt;
      if (upV[ch])      cntNext = cnt + 1'b1;
      else if (dnV[ch]) cntNext = cnt - 1'b1;
    end

    assign wrapV[ch]  = (upV[ch] && (cnt == CNT_MAX)) || (dnV[ch] && (cnt == '0));
    assign matchV[ch] = (upV[ch] || dnV[ch]) && (cntNext == cmpArr[ch]);
    assign cntArr[ch] = cnt;

    always_ff @(posedge clk) begin
      if (!rstN) cnt <= '0;
      else       cnt <= cntNext;
    end

    // R12: a wrap lands on the opposite end of the range
    a_r12_wrap_end: assert property (@(posedge clk) disable iff (!rstN)
      wrapV[ch] |=> ((cnt == '0) || (cnt == CNT_MAX)));
  end

  assign count0 = cntArr[0];
  assign count1 = cntArr[1];

  always_comb begin
    setV            = '0;
    setV[F_TRANS]   = strobe.evTrans;
    setV[F_MATCH0]  = matchV[0];
    setV[F_MATCH1]  = matchV[1];
    setV[F_WRAP]    = |wrapV;
    setV[F_DIRCHG]  = strobe.evDirChg;
    setV[F_QERR]    = strobe.evQerr;
    setV[F_FLSTART] = strobe.evFlStart;
    setV[F_FLSTOP]  = strobe.evFlStop;
  end

  always_ff @(posedge clk) begin
    if (!rstN) flags <= '0;
    else       flags <= (flags & ~flagClr) | setV;
  end

  assign irq = |(flags & flagEn);

  for (genvar f = 0; f < NFLAG; f++) begin : g_flagChk
    // R13: a set flag stays set unless its clear strobe is given
    a_r13_sticky: assert property (@(posedge clk) disable iff (!rstN)
      (flags[f] && !flagClr[f]) |=> flags[f]);
    // R13: an event in the clear cycle wins
    a_r13_set_wins: assert property (@(posedge clk) disable iff (!rstN)
      setV[f] |=> flags[f]);
  end

endmodule

// File: rtl/quad_pulse_counter.sv
module quad_pulse_counter
  import qpc_pkg::*;
#(
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inA,
  input  logic             inB,
  input  logic [1:0]       mode,
  input  logic             flutStopEn,
  input  logic             flutDualEn,
  input  logic [CNT_W-1:0] cmpVal0,
  input  logic [CNT_W-1:0] cmpVal1,
  input  logic [7:0]       flagEn,
  input  logic [7:0]       flagClr,
  output logic [CNT_W-1:0] count0,
  output logic [CNT_W-1:0] count1,
  output logic             dirCw,
  output logic [1:0]       qState,
  output logic             prevA,
  output logic             prevB,
  output logic [3:0]       dirHist,
  output logic             flutActive,
  output logic [7:0]       flags,
  output logic             irq
);

  ctrlStrobe_t strobe;
  logic [1:0]  prevLvl;

  qpc_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .inA        (inA),
    .inB        (inB),
    .mode       (mode),
    .flutStopEn (flutStopEn),
    .flutDualEn (flutDualEn),
    .strobe     (strobe),
    .dirCw      (dirCw),
    .qState     (qState),
    .prevLvl    (prevLvl),
    .dirHist    (dirHist),
    .flutActive (flutActive)
  );

  qpc_datapath #(.CNT_W(CNT_W)) u_datapath (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .cmpVal0 (cmpVal0),
    .cmpVal1 (cmpVal1),
    .flagEn  (flagEn),
    .flagClr (flagClr),
    .count0  (count0),
    .count1  (count1),
    .flags   (flags),
    .irq     (irq)
  );

  assign prevA = prevLvl[0];
  assign prevB = prevLvl[1];

  // R2: counters hold while the block is off
  a_r2_off_hold: assert property (@(posedge clk) disable iff (!rstN)
    (mode == 2'd0) |=> ((count0 == $past(count0)) && (count1 == $past(count1))));
  // R9: counters freeze during flutter with the stop response
  a_r9_freeze: assert property (@(posedge clk) disable iff (!rstN)
    (flutActive && flutStopEn) |=> ((count0 == $past(count0)) && (count1 == $past(count1))));
  // R6: an illegal jump does not move counter 0 in quadrature decoding
  a_r6_err_nocount: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.evQerr && !(flutActive && flutDualEn)) |=> (count0 == $past(count0)));
  // R5: counter 0 moves by at most one per cycle
  a_r5_unit_step: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((count0 == $past(count0)) ||
              (count0 == CNT_W'($past(count0) + 1'b1)) ||
              (count0 == CNT_W'($past(count0) - 1'b1))));

endmodule

// File: tb/quad_pulse_counter_bench.sv
module quad_pulse_counter_bench;

  localparam int W    = 8;
  localparam int MASK = (1 << W) - 1;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         inA = 1'b0, inB = 1'b0;
  logic [1:0]   mode = 2'd0;
  logic         flutStopEn = 1'b0, flutDualEn = 1'b0;
  logic [W-1:0] cmpVal0 = '1, cmpVal1 = '1;
  logic [7:0]   flagEn = 8'h00, flagClr = 8'h00;
  logic [W-1:0] count0, count1;
  logic         dirCw, prevA, prevB, flutActive, irq;
  logic [1:0]   qState;
  logic [3:0]   dirHist;
  logic [7:0]   flags;

  int checks = 0;
  int errors = 0;

  // reference model state
  int         mC0, mC1, mMode;
  logic [1:0] mLvl, mPrev;
  logic       mDir, mFlut;
  logic [3:0] mHist;
  logic [7:0] mFlags;

  always #5 clk = ~clk;

  quad_pulse_counter #(.CNT_W(W)) u_quad_pulse_counter (
    .clk(clk), .rstN(rstN), .inA(inA), .inB(inB), .mode(mode),
    .flutStopEn(flutStopEn), .flutDualEn(flutDualEn),
    .cmpVal0(cmpVal0), .cmpVal1(cmpVal1), .flagEn(flagEn), .flagClr(flagClr),
    .count0(count0), .count1(count1), .dirCw(dirCw), .qState(qState),
    .prevA(prevA), .prevB(prevB), .dirHist(dirHist), .flutActive(flutActive),
    .flags(flags), .irq(irq)
  );

  function automatic int cwIndex(input logic [1:0] c);
    case (c)
      2'b00:   return 0;
      2'b01:   return 1;
      2'b11:   return 2;
      default: return 3;
    endcase
  endfunction

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic checkAll(input string tag);
    chk(tag, "count0", int'(count0), mC0);
    chk(tag, "count1", int'(count1), mC1);
    chk(tag, "flags", int'(flags), int'(mFlags));
    chk(tag, "irq", int'(irq), int'(|(mFlags & flagEn)));
    chk(tag, "dirCw", int'(dirCw), int'(mDir));
    chk(tag, "dirHist", int'(dirHist), int'(mHist));
    chk(tag, "flutActive", int'(flutActive), int'(mFlut));
    chk(tag, "qState", int'(qState), int'(mLvl));
    chk(tag, "prev", int'({prevB, prevA}), int'(mPrev));
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; inA = 1'b0; inB = 1'b0; flagClr = 8'h00;
    @(negedge clk);
    @(negedge clk);
    rstN = 1'b1;
    mC0 = 0; mC1 = 0; mLvl = 2'b00; mPrev = 2'b00;
    mDir = 1'b0; mFlut = 1'b0; mHist = 4'h0; mFlags = 8'h00;
  endtask

  task automatic setMode(input int m);
    @(negedge clk);
    mode = 2'(m);
    mMode = m;
    if (m != 3) mFlut = 1'b0;
  endtask

  task automatic step(input logic a, input logic b, input logic [7:0] clr, input string tag);
    logic [1:0] cur;
    logic [3:0] hn;
    logic [7:0] setV;
    int d;
    bit isQ, fd, hold, sCw, sCcw, stp, r0, r1, up0, dn0, up1;
    @(negedge clk);
    inA = a; inB = b; flagClr = clr;
    cur  = {b, a};
    isQ  = (mMode == 3);
    d    = (cwIndex(cur) - cwIndex(mLvl) + 4) % 4;
    sCw  = isQ && (d == 1);
    sCcw = isQ && (d == 3);
    stp  = sCw || sCcw;
    r0   = cur[0] && !mLvl[0];
    r1   = cur[1] && !mLvl[1];
    fd   = mFlut && flutDualEn && isQ;
    hold = mFlut && flutStopEn;
    up0  = !hold && ((((mMode == 1) || (mMode == 2) || fd) && r0) || (isQ && !fd && sCw));
    dn0  = !hold && isQ && !fd && sCcw;
    up1  = !hold && ((mMode == 2) || fd) && r1;
    setV = 8'h00;
    setV[0] = (mMode != 0) && (cur != mLvl);
    if (up0) begin
      if (mC0 == MASK) setV[3] = 1'b1;
      mC0 = (mC0 + 1) & MASK;
      if (mC0 == int'(cmpVal0)) setV[1] = 1'b1;
    end
    if (dn0) begin
      if (mC0 == 0) setV[3] = 1'b1;
      mC0 = (mC0 - 1) & MASK;
      if (mC0 == int'(cmpVal0)) setV[1] = 1'b1;
    end
    if (up1) begin
      if (mC1 == MASK) setV[3] = 1'b1;
      mC1 = (mC1 + 1) & MASK;
      if (mC1 == int'(cmpVal1)) setV[2] = 1'b1;
    end
    hn = {mHist[2:0], sCw};
    if (stp) begin
      setV[4] = (sCw != mDir);
      mDir = sCw;
      if (!mFlut && (hn == 4'b1010 || hn == 4'b0101)) begin
        setV[6] = 1'b1; mFlut = 1'b1;
      end else if (mFlut && (hn == 4'b0000 || hn == 4'b1111)) begin
        setV[7] = 1'b1; mFlut = 1'b0;
      end
      mHist = hn;
    end
    setV[5] = isQ && (d == 2);
    mFlags = (mFlags & ~clr) | setV;
    if (cur != mLvl) mPrev = mLvl;
    mLvl = cur;
    @(posedge clk);
    @(negedge clk);
    flagClr = 8'h00;
    checkAll(tag);
  endtask

  // walk one Gray position clockwise (dir=1) or counter-clockwise
  task automatic quadMove(input bit cw, input string tag);
    logic [1:0] nxt;
    int idx;
    idx = (cwIndex(mLvl) + (cw ? 1 : 3)) % 4;
    case (idx)
      0: nxt = 2'b00;
      1: nxt = 2'b01;
      2: nxt = 2'b11;
      default: nxt = 2'b10;
    endcase
    step(nxt[0], nxt[1], 8'h00, tag);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : stimulus
    mMode = 0;
    doReset();
    @(negedge clk);
    checkAll("R1");

    // R2: off mode, sweep all code pairs
    flagEn = 8'hFF;
    for (int s = 0; s < 4; s++)
      for (int t = 0; t < 4; t++) begin
        step(s[0], s[1], 8'h00, "R2");
        step(t[0], t[1], 8'h00, "R2");
      end

    // R3: single channel sweep
    setMode(1);
    flagEn = 8'h02;
    cmpVal0 = 8'd3;
    for (int s = 0; s < 4; s++)
      for (int t = 0; t < 4; t++) begin
        step(s[0], s[1], 8'h00, "R3");
        step(t[0], t[1], 8'h00, "R11");
      end

    // R13: clear all, then clear with a coincident event
    step(mLvl[0], mLvl[1], 8'hFF, "R13");
    step(!mLvl[0], mLvl[1], 8'h01, "R13");
    step(mLvl[0], mLvl[1], 8'hFE, "R14");

    // R4: dual channel sweep
    doReset();
    setMode(2);
    cmpVal1 = 8'd2;
    flagEn = 8'h04;
    for (int s = 0; s < 4; s++)
      for (int t = 0; t < 4; t++) begin
        step(s[0], s[1], 8'h00, "R4");
        step(t[0], t[1], 8'h00, "R11");
      end

    // R5 R6: quadrature sweep over all pairs
    doReset();
    setMode(3);
    flagEn = 8'h20;
    for (int s = 0; s < 4; s++)
      for (int t = 0; t < 4; t++) begin
        step(s[0], s[1], 8'h00, "R5");
        step(t[0], t[1], 8'h00, "R6");
      end

    // R5 R7 R12: clean rotation, down-wrap from zero
    doReset();
    setMode(3);
    flagEn = 8'h18;
    quadMove(1'b0, "R12");
    for (int i = 0; i < 6; i++) quadMove(1'b1, "R5");
    for (int i = 0; i < 6; i++) quadMove(1'b0, "R7");

    // R8 R9: flutter with freeze response
    doReset();
    setMode(3);
    flutStopEn = 1'b1;
    flagEn = 8'hC0;
    for (int i = 0; i < 6; i++) quadMove(i % 2 == 0, "R9");
    for (int i = 0; i < 5; i++) quadMove(1'b1, "R8");
    setMode(1);
    step(mLvl[0], mLvl[1], 8'h00, "R8");

    // R10: flutter with dual fallback
    doReset();
    setMode(3);
    flutStopEn = 1'b0;
    flutDualEn = 1'b1;
    for (int i = 0; i < 4; i++) quadMove(i % 2 == 0, "R8");
    for (int s = 0; s < 4; s++)
      for (int t = 0; t < 4; t++) begin
        step(s[0], s[1], 8'h00, "R10");
        step(t[0], t[1], 8'h00, "R10");
      end
    flutDualEn = 1'b0;

    // R12: up-wrap in single mode
    doReset();
    setMode(1);
    flagEn = 8'h08;
    for (int i = 0; i < MASK + 2; i++) begin
      step(1'b1, 1'b0, 8'h00, "R12");
      step(1'b0, 1'b0, 8'h00, "R12");
    end

    // R14: enable sweep over the current flags
    for (int e = 0; e < 8; e++) begin
      flagEn = 8'(1 << e);
      step(mLvl[0], mLvl[1], 8'h00, "R14");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule